// File: doc/BRIEF.md
# Receiver Error Logger with Sample Conditioning

This block sits behind the decoder of a digital audio receiver. Each frame the decoder reports the error events it saw as single-cycle pulses on a seven-bit event bus. The bits are:

| Bit | Event |
|-----|-------|
| 0 | loss of lock |
| 1 | validity flag |
| 2 | weak signal confidence |
| 3 | bi-phase coding |
| 4 | parity |
| 5 | subcode CRC |
| 6 | channel-status CRC |

An enable mask decides which events count. Counted events are latched into a sticky status word. That word stays set until the host reads it. Counted events also drive an error pin pulse and a level interrupt.

The same counted events condition the audio sample that arrives with them. A two-bit mode picks what happens to that sample. It can be replaced by the last clean sample, forced to zero, or passed unchanged. The two CRC events are frame-level checks and never alter audio.

All outputs are registered. The status word, the error pin and the conditioned sample each appear one clock after the inputs that cause them. The interrupt follows the status word directly.

Top module: `rx_error_logger`

## Requirements
- R1: After reset the status word, error pin, interrupt, output sample and output strobe are zero. A status bit, once set, stays set until a read clears it.
- R2: An event bit counts only when its mask bit is 1. An event whose mask bit is 0 sets no status bit, produces no error pin pulse and does not alter the audio.
- R3: A read strobe clears the status word on the following clock edge. While the strobe is high, `err_stat` still shows the value being read.
- R4: An enabled event in the same cycle as a read strobe leaves its status bit set after the read.
- R5: `err_pin` is high for exactly the one clock that follows each input cycle carrying at least one enabled event.
- R6: `irq` is high exactly when any status bit is set.
- R7: Hold mode 00 applies to a sample that arrives together with an enabled audio-affecting event (bits 0 to 4). In this mode the output repeats the last clean sample, which is 0 if no clean sample has been seen since reset.
- R8: Hold mode 01 replaces such a sample with zero.
- R9: Hold modes 10 and 11 pass such a sample unchanged.
- R10: Enabled events on bits 5 and 6 never alter the output sample, but they are still recorded.
- R11: The output sample and its strobe change one clock after `smp_vld`. The output sample holds its value when no sample arrives. The last clean sample is updated only by samples that arrive with no enabled audio-affecting event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 7 | Error event pulses, bit order as in R7 and R10 |
| err_mask | input | 7 | Enable mask, 1 = event counts |
| hold_mode | input | 2 | Audio action for affected samples |
| rd_stb | input | 1 | Status read strobe, clears on read |
| smp_in | input | 24 | Incoming audio sample |
| smp_vld | input | 1 | Sample strobe |
| err_stat | output | 7 | Sticky status word |
| err_pin | output | 1 | One-clock error pulse |
| irq | output | 1 | Level interrupt |
| smp_out | output | 24 | Conditioned sample |
| smp_out_vld | output | 1 | Conditioned sample strobe |

## Verification
The status word, the error pin and the conditioned sample are all due one clock after the inputs that cause them. The interrupt is due in the same cycle as the status word it reflects. The bench advances a behavioural model at each rising edge from the inputs it drove at the previous falling edge. It then compares every output at the next falling edge, so each result is checked exactly in the cycle it is due. Directed phases cover masking, a read that coincides with an event, every hold mode and the CRC exemption before a long random phase.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
   localparam int unsigned EVT_LOCK   = 0;
   localparam int unsigned EVT_VALID  = 1;
   localparam int unsigned EVT_CONF   = 2;
   localparam int unsigned EVT_BIPH   = 3;
   localparam int unsigned EVT_PAR    = 4;
   localparam int unsigned EVT_QCRC   = 5;
   localparam int unsigned EVT_CSCRC  = 6;
   localparam int unsigned EVT_COUNT  = 7;

   typedef enum logic [1:0] {
      HM_REPEAT = 2'b00,
      HM_ZERO   = 2'b01,
      HM_PASS   = 2'b10,
      HM_PASS_X = 2'b11
   } hold_mode_e;
endpackage

// File: rtl/rxe_sticky_bank.sv
module rxe_sticky_bank #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr,
   output logic [N-1:0] stat,
   output logic         any
);
   if (N < 1) begin : g_bad_n
      $error("rxe_sticky_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= (stat[i] & ~clr) | set_vec[i];
      end

      assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[i] && !clr) |=> stat[i]);
      assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat[i] && !set_vec[i]) |=> !stat[i]);
      assert_read_keeps_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && set_vec[i]) |=> stat[i]);
      assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !set_vec[i]) |=> !stat[i]);
   end

   assign any = |stat;
endmodule

// File: rtl/rxe_sample_cond.sv
module rxe_sample_cond
   import rxe_pkg::*;
#(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  hold_mode_e   mode,
   input  logic [W-1:0] s_in,
   input  logic         s_vld,
   output logic [W-1:0] s_out,
   output logic         s_ovld
);
   if (W < 1) begin : g_bad_w
      $error("rxe_sample_cond: W must be at least 1");
   end

   logic [W-1:0] last_clean;
   logic [W-1:0] chosen;

   always_comb begin
      chosen = s_in;
      if (hit) begin
         unique case (mode)
            HM_REPEAT: chosen = last_clean;
            HM_ZERO:   chosen = '0;
            default:   chosen = s_in;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_out      <= '0;
         s_ovld     <= 1'b0;
         last_clean <= '0;
      end else begin
         s_ovld <= s_vld;
         if (s_vld) begin
            s_out <= chosen;
            if (!hit) last_clean <= s_in;
         end
      end
   end

   assert_clean_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld && !hit) |=> (s_out == $past(s_in)));
   assert_zero_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld && hit && mode == HM_ZERO) |=> (s_out == '0));
   assert_pass_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld && hit && mode[1]) |=> (s_out == $past(s_in)));
   assert_out_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !s_vld |=> $stable(s_out));
endmodule

// File: rtl/rx_error_logger.sv
module rx_error_logger
   import rxe_pkg::*;
#(
   parameter int unsigned       SAMPLE_W  = 24,
   parameter int unsigned       ERR_N     = EVT_COUNT,
   parameter logic [ERR_N-1:0]  AUDIO_SEL = 7'b001_1111
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ERR_N-1:0]    err_evt,
   input  logic [ERR_N-1:0]    err_mask,
   input  logic [1:0]          hold_mode,
   input  logic                rd_stb,
   input  logic [SAMPLE_W-1:0] smp_in,
   input  logic                smp_vld,
   output logic [ERR_N-1:0]    err_stat,
   output logic                err_pin,
   output logic                irq,
   output logic [SAMPLE_W-1:0] smp_out,
   output logic                smp_out_vld
);
   if (ERR_N != EVT_COUNT) begin : g_bad_cnt
      $error("rx_error_logger: ERR_N must match the event map");
   end

   logic [ERR_N-1:0] enabled;
   logic             audio_hit;
   hold_mode_e       mode_e;

   assign enabled   = err_evt & err_mask;
   assign audio_hit = |(enabled & AUDIO_SEL);
   assign mode_e    = hold_mode_e'(hold_mode);

   rxe_sticky_bank #(.N(ERR_N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (enabled),
      .clr     (rd_stb),
      .stat    (err_stat),
      .any     (irq)
   );

   rxe_sample_cond #(.W(SAMPLE_W)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (audio_hit),
      .mode   (mode_e),
      .s_in   (smp_in),
      .s_vld  (smp_vld),
      .s_out  (smp_out),
      .s_ovld (smp_out_vld)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_pin <= 1'b0;
      else        err_pin <= |enabled;
   end

   assert_pin_has_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_pin |-> irq);
   assert_pin_one_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled == '0) |=> !err_pin);
   assert_crc_no_audio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && (enabled & AUDIO_SEL) == '0) |=> (smp_out == $past(smp_in)));
   assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> smp_out_vld);
endmodule

// File: tb/rx_error_logger_bench.sv
module rx_error_logger_bench;
   localparam int W = 24;
   localparam int N = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] err_evt = '0, err_mask = '0;
   logic [1:0]   hold_mode = 2'b00;
   logic         rd_stb = 1'b0;
   logic [W-1:0] smp_in = '0;
   logic         smp_vld = 1'b0;
   logic [N-1:0] err_stat;
   logic         err_pin, irq, smp_out_vld;
   logic [W-1:0] smp_out;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   rx_error_logger u_rx_error_logger (
      .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_mask(err_mask),
      .hold_mode(hold_mode), .rd_stb(rd_stb), .smp_in(smp_in), .smp_vld(smp_vld),
      .err_stat(err_stat), .err_pin(err_pin), .irq(irq), .smp_out(smp_out),
      .smp_out_vld(smp_out_vld));

   // behavioural reference model
   logic [N-1:0] m_stat = '0;
   logic         m_pin = 1'b0, m_ovld = 1'b0;
   logic [W-1:0] m_out = '0, m_last = '0;
   string        m_why = "R1";

   always @(posedge clk) begin
      logic [N-1:0] en;
      en = err_evt & err_mask;
      if (!rst_n) begin
         m_stat = '0; m_pin = 0; m_ovld = 0; m_out = '0; m_last = '0; m_why = "R1";
      end else begin
         m_stat = (rd_stb ? '0 : m_stat) | en;
         m_pin  = (en != 0);
         m_ovld = smp_vld;
         if (smp_vld) begin
            if ((en & 7'h1F) != 0) begin
               if (hold_mode == 2'b00)      begin m_out = m_last; m_why = "R7"; end
               else if (hold_mode == 2'b01) begin m_out = '0;     m_why = "R8"; end
               else                         begin m_out = smp_in; m_why = "R9"; end
            end else begin
               m_out = smp_in; m_last = smp_in;
               m_why = ((en & 7'h60) != 0) ? "R10" : "R2";
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every cycle at the falling edge
   always @(negedge clk) begin
      chk(err_stat == m_stat, "R1", err_stat, m_stat);
      chk(irq == (m_stat != 0), "R6", irq, (m_stat != 0));
      chk(err_pin == m_pin, "R5", err_pin, m_pin);
      chk(smp_out_vld == m_ovld, "R11", smp_out_vld, m_ovld);
      chk(smp_out == m_out, m_why, smp_out, m_out);
   end

   task automatic drive(input logic [N-1:0] e, input logic [N-1:0] m, input logic [1:0] hm,
                        input bit rd, input logic [W-1:0] s, input bit v);
      @(negedge clk);
      #0.5;
      err_evt = e; err_mask = m; hold_mode = hm; rd_stb = rd; smp_in = s; smp_vld = v;
   endtask

   initial begin : watchdog
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);  // reset state, R1
      drive('0, '0, 2'b00, 0, '0, 0);
      rst_n = 1'b1;
      // R1 sticky, R5 pulse, R6 irq
      drive(7'h01, 7'h7F, 2'b10, 0, 24'h111111, 1);
      drive('0, 7'h7F, 2'b10, 0, 24'h222222, 1);
      drive('0, 7'h7F, 2'b10, 0, '0, 0);
      // R3 read clears
      drive('0, 7'h7F, 2'b10, 1, '0, 0);
      drive('0, 7'h7F, 2'b10, 0, '0, 0);
      // R2 masked events: nothing recorded, audio untouched
      drive(7'h1F, 7'h00, 2'b01, 0, 24'h333333, 1);
      drive('0, 7'h00, 2'b01, 0, '0, 0);
      // R4 event coincident with read
      drive(7'h08, 7'h7F, 2'b10, 0, '0, 0);
      drive(7'h04, 7'h7F, 2'b10, 1, '0, 0);
      drive('0, 7'h7F, 2'b10, 0, '0, 0);
      drive('0, 7'h7F, 2'b10, 1, '0, 0);
      // R7 repeat last clean
      drive('0, 7'h7F, 2'b00, 0, 24'hABCDEF, 1);
      drive(7'h10, 7'h7F, 2'b00, 0, 24'h555555, 1);
      drive(7'h02, 7'h7F, 2'b00, 0, 24'h666666, 1);
      // R8 zero, R9 pass (10 and 11)
      drive(7'h01, 7'h7F, 2'b01, 0, 24'h777777, 1);
      drive(7'h01, 7'h7F, 2'b10, 0, 24'h888888, 1);
      drive(7'h01, 7'h7F, 2'b11, 0, 24'h999999, 1);
      // R10 CRC events enabled, audio unchanged, still recorded
      drive(7'h60, 7'h7F, 2'b01, 1, 24'hAAAAAA, 1);
      drive(7'h20, 7'h7F, 2'b00, 0, 24'hBBBBBB, 1);
      // R11 output holds with no sample
      drive('0, 7'h7F, 2'b00, 0, 24'hCCCCCC, 0);
      drive('0, 7'h7F, 2'b00, 0, 24'hCCCCCC, 0);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [N-1:0] e;
         e = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
         drive(e, N'($urandom), 2'($urandom), ($urandom_range(0, 7) == 0),
               W'($urandom), $urandom_range(0, 1) == 1);
      end
      drive('0, '0, 2'b00, 0, '0, 0);
      @(negedge clk);
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule